// File: doc/BRIEF.md
# Packet Receive Deframer with CRC Check

This block sits behind a demodulator that delivers one detected byte per strobe. It hunts for a synchronisation header made of zero bytes followed by a delimiter byte. It then takes the next byte as the frame length and writes that many bytes into a 64-word by 16-bit receive store. Those bytes are the payload followed by two check bytes. A 16-bit CRC runs over every stored byte as it arrives, and the result is judged when the last byte lands.

The host is told nothing until the whole frame is stored. At that point a single interrupt comes up, together with the frame length and a pass/fail flag for the CRC. The host reads the stored words through a synchronous read port, then clears the interrupt. Until it does, the receiver is locked and ignores further input, so the stored frame cannot be overwritten.

Top module: `rxd_deframer`

## Requirements
- R1: After reset, irq_o and crc_ok_o are 0 and the receiver is in header search.
- R2: A frame is accepted only after at least four consecutive 0x00 bytes followed by 0xA7. Any other byte during the search, including 0xA7 after fewer than four zeros, restarts the zero count.
- R3: The byte after 0xA7 is the length L. A value from 2 to 127 opens the frame. Any other value aborts it without an interrupt, and the receiver returns to header search.
- R4: Frame byte k (k = 0 to L-1, payload first, then the two check bytes) is stored in word k/2, in bits 15:8 when k is even and in bits 7:0 when k is odd.
- R5: The CRC uses the reflected polynomial 0x8408 with initial value 0, taking each byte least significant bit first, over all L bytes. The check value is appended low byte first. crc_ok_o is 1 exactly when the final remainder is zero.
- R6: irq_o rises on the clock edge that accepts byte L-1, and is visible in the cycle after it. frame_len_o then equals L.
- R7: While irq_o is high, input bytes are ignored: frame_len_o, crc_ok_o and the stored words stay unchanged.
- R8: irq_clear_i high while irq_o is high drops irq_o at the next edge. A byte presented in that same cycle is ignored, and the header search starts with the following byte.
- R9: rd_data_o presents the word at rd_addr_i one clock edge after the address is applied.
- R10: Cycles with byte_valid_i low have no effect, so bytes may arrive with gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Strobe qualifying byte_i |
| byte_i | input | 8 | Detected byte from the demodulator |
| irq_clear_i | input | 1 | Host acknowledge of the pending frame |
| rd_addr_i | input | 6 | Word address of the receive store |
| irq_o | output | 1 | Frame-complete interrupt, held until cleared |
| frame_len_o | output | 7 | Length byte of the stored frame |
| crc_ok_o | output | 1 | CRC remainder was zero |
| rd_data_o | output | 16 | Registered read data from the receive store |

## Verification
Two events can meet in one cycle: the host acknowledge that releases the lockout, and the arrival of a new header byte. The bench presents a 0x00 byte in the same cycle as irq_clear_i. It then sends only three more zeros and the delimiter, followed by a length and data. No interrupt may follow, because the byte that arrived with the clear must not count toward the preamble. A frame with a complete header sent afterwards must then complete, which shows the search resumed on the byte after the clear.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [1:0] {ST_SEARCH, ST_LEN, ST_DATA, ST_HOLD} rx_state_e;

  localparam logic [7:0]  PRE_BYTE  = 8'h00;
  localparam logic [7:0]  SFD_BYTE  = 8'hA7;
  localparam int          PRE_COUNT = 4;
  localparam int          LEN_MIN   = 2;
  localparam int          LEN_MAX   = 127;
  localparam logic [15:0] CRC_POLY  = 16'h8408;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rxd_hdr_fsm.sv
module rxd_hdr_fsm import rxd_pkg::*; #(
  parameter int LEN_W = 7,
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  input  logic             irq_clear_i,
  input  logic             crc_zero_i,
  output logic             data_we_o,
  output logic [IDX_W-1:0] data_idx_o,
  output logic             crc_clr_o,
  output logic             irq_o,
  output logic [LEN_W-1:0] frame_len_o,
  output logic             crc_ok_o
);
  localparam int PCNT_W = $clog2(PRE_COUNT + 1);

  rx_state_e         state_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic [LEN_W-1:0]  remain_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              ok_q;
  logic              len_ok;
  logic              last_byte;

  assign len_ok    = (byte_i >= 8'(LEN_MIN)) && (byte_i <= 8'(LEN_MAX));
  assign data_we_o = (state_q == ST_DATA) && byte_valid_i;
  assign last_byte = data_we_o && (remain_q == LEN_W'(1));
  assign crc_clr_o = (state_q == ST_LEN) && byte_valid_i;
  assign data_idx_o  = idx_q;
  assign irq_o       = (state_q == ST_HOLD);
  assign frame_len_o = len_q;
  assign crc_ok_o    = ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_SEARCH;
      pcnt_q   <= '0;
      remain_q <= '0;
      idx_q    <= '0;
      len_q    <= '0;
      ok_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_SEARCH: if (byte_valid_i) begin
          if (byte_i == PRE_BYTE) begin
            if (pcnt_q != PCNT_W'(PRE_COUNT)) pcnt_q <= pcnt_q + 1'b1;
          end else if (byte_i == SFD_BYTE && pcnt_q == PCNT_W'(PRE_COUNT)) begin
            state_q <= ST_LEN;
            pcnt_q  <= '0;
          end else begin
            pcnt_q <= '0;
          end
        end
        ST_LEN: if (byte_valid_i) begin
          if (len_ok) begin
            state_q  <= ST_DATA;
            remain_q <= byte_i[LEN_W-1:0];
            len_q    <= byte_i[LEN_W-1:0];
            idx_q    <= '0;
          end else begin
            state_q <= ST_SEARCH;
          end
        end
        ST_DATA: if (byte_valid_i) begin
          idx_q    <= idx_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (last_byte) begin
            state_q <= ST_HOLD;
            ok_q    <= crc_zero_i;
          end
        end
        ST_HOLD: if (irq_clear_i) begin
          state_q <= ST_SEARCH;
          pcnt_q  <= '0;
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  // R3: only legal lengths reach the host
  p_len_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (frame_len_o >= LEN_W'(LEN_MIN)) && (frame_len_o <= LEN_W'(LEN_MAX)));
  // R6: byte count at completion matches the length byte
  p_idx_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> idx_q == IDX_W'(frame_len_o));
  // R8: pending interrupt survives until cleared
  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clear_i |=> irq_o);
  p_clear_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && irq_clear_i |=> !irq_o);
endmodule

// File: rtl/rxd_crc16.sv
module rxd_crc16 import rxd_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_o,
  output logic        next_zero_o
);
  logic [15:0] crc_q;
  logic [15:0] crc_d;

  assign crc_d       = crc16_byte(crc_q, byte_i);
  assign next_zero_o = (crc_d == 16'h0000);
  assign crc_o       = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_d;
  end
endmodule

// File: rtl/rxd_pack_buf.sv
module rxd_pack_buf #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int LANE_W = $clog2(WORD_W / 8),
  parameter int IDX_W  = ADDR_W + LANE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int LANES = WORD_W / 8;

  logic [ADDR_W-1:0] wr_addr;
  logic [LANE_W-1:0] wr_pos;

  assign wr_addr = idx_i[IDX_W-1:LANE_W];
  assign wr_pos  = idx_i[LANE_W-1:0];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;
    // first byte of a word lands in the most significant lane
    always_ff @(posedge clk_i) begin
      if (we_i && wr_pos == LANE_W'(LANES - 1 - l)) mem_q[wr_addr] <= byte_i;
      rd_q <= mem_q[rd_addr_i];
    end
    assign rd_data_o[l*8 +: 8] = rd_q;
  end
endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer import rxd_pkg::*; #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 7,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LANE_W = $clog2(WORD_W / 8),
  localparam int IDX_W  = ADDR_W + LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              irq_clear_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              irq_o,
  output logic [LEN_W-1:0]  frame_len_o,
  output logic              crc_ok_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic             data_we;
  logic [IDX_W-1:0] data_idx;
  logic             crc_clr;
  logic             crc_zero;
  logic [15:0]      crc_val;

  rxd_hdr_fsm #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .irq_clear_i,
    .crc_zero_i (crc_zero),
    .data_we_o  (data_we),
    .data_idx_o (data_idx),
    .crc_clr_o  (crc_clr),
    .irq_o, .frame_len_o, .crc_ok_o
  );

  rxd_crc16 u_crc (
    .clk_i, .rst_ni,
    .clr_i       (crc_clr),
    .en_i        (data_we),
    .byte_i,
    .crc_o       (crc_val),
    .next_zero_o (crc_zero)
  );

  rxd_pack_buf #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_buf (
    .clk_i,
    .we_i      (data_we),
    .idx_i     (data_idx),
    .byte_i,
    .rd_addr_i,
    .rd_data_o
  );

  // R5: reported flag agrees with the remainder held by the CRC engine
  p_crc_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> crc_ok_o == (crc_val == 16'h0000));
  // R7: pending frame is frozen
  p_hold_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(irq_o) |-> $stable(frame_len_o) && $stable(crc_ok_o));
  p_hold_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !data_we);
endmodule

// File: tb/tb_rxd_deframer.sv
module tb_rxd_deframer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = '0;
  logic        irq_clear = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        irq;
  logic [6:0]  frame_len;
  logic        crc_ok;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] fb [128];

  always #10 clk = ~clk;

  rxd_deframer dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_in),
    .irq_clear_i(irq_clear), .rd_addr_i(rd_addr), .irq_o(irq),
    .frame_len_o(frame_len), .crc_ok_o(crc_ok), .rd_data_o(rd_data)
  );

  // {len[23:16], seed[15:8], corrupt[0]}
  localparam logic [23:0] VEC [5] = '{
    {8'd2,   8'h11, 8'h00},
    {8'd3,   8'h22, 8'h00},
    {8'd20,  8'h35, 8'h00},
    {8'd127, 8'h4C, 8'h00},
    {8'd10,  8'h5D, 8'h01}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'h8408;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic build(input int len, input logic [7:0] seed, input logic corrupt);
    logic [15:0] c = '0;
    for (int i = 0; i < len - 2; i++) begin
      fb[i] = 8'(seed + i * 29 + (i >> 2));
      c = crc_step(c, fb[i]);
    end
    fb[len-2] = c[7:0];
    fb[len-1] = c[15:8];
    if (corrupt) fb[0] = fb[0] ^ 8'h08;
  endtask

  task automatic send(input logic [7:0] b, input bit gap);
    byte_valid = 1'b1;
    byte_in    = b;
    @(negedge clk);
    byte_valid = 1'b0;
    if (gap) @(negedge clk);
  endtask

  task automatic header(input int npre, input logic [7:0] len);
    for (int i = 0; i < npre; i++) send(8'h00, 1'b0);
    send(8'hA7, 1'b0);
    send(len, 1'b0);
  endtask

  // sends frame from fb, checks irq timing (R6)
  task automatic send_body(input int len, input bit gap, input bit expect_irq);
    for (int i = 0; i < len - 1; i++) send(fb[i], gap);
    if (expect_irq) chk(irq == 1'b0, "R6 irq early", int'(irq), 0);
    send(fb[len-1], 1'b0);
    if (expect_irq) chk(irq == 1'b1, "R6 irq after last byte", int'(irq), 1);
  endtask

  task automatic rd(input int addr, output logic [15:0] d);
    rd_addr = 6'(addr);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic verify_store(input int len, input string tag);
    logic [15:0] d;
    for (int w = 0; w < (len + 1) / 2; w++) begin
      rd(w, d);
      if (2 * w + 1 < len)
        chk(d == {fb[2*w], fb[2*w+1]}, tag, int'(d), int'({fb[2*w], fb[2*w+1]}));
      else
        chk(d[15:8] == fb[2*w], tag, int'(d[15:8]), int'(fb[2*w]));
    end
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk(irq == 1'b0, "R8 clear drops irq", int'(irq), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    logic [15:0] w0;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0 && crc_ok == 1'b0, "R1 reset outputs", int'({irq, crc_ok}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 idle after reset", int'(irq), 0);

    // table of frames: R2 R4 R5 R6 R9 R10
    for (int v = 0; v < 5; v++) begin
      int len = int'(VEC[v][23:16]);
      build(len, VEC[v][15:8], VEC[v][0]);
      header(4 + v % 3, 8'(len));
      send_body(len, v[0], 1'b1);
      chk(frame_len == 7'(len), "R6 frame_len", int'(frame_len), len);
      chk(crc_ok == !VEC[v][0], "R5 crc flag", int'(crc_ok), int'(!VEC[v][0]));
      verify_store(len, "R4 R9 stored word");
      clear_irq();
    end

    // R3: illegal lengths abort, no interrupt
    header(4, 8'd1);
    for (int i = 0; i < 4; i++) send(8'h5A, 1'b0);
    chk(irq == 1'b0, "R3 length 1 aborts", int'(irq), 0);
    header(4, 8'd128);
    for (int i = 0; i < 130; i++) send(8'h3C, 1'b0);
    chk(irq == 1'b0, "R3 length 128 aborts", int'(irq), 0);
    header(4, 8'd0);
    for (int i = 0; i < 4; i++) send(8'h5A, 1'b0);
    chk(irq == 1'b0, "R3 length 0 aborts", int'(irq), 0);

    // R2: short preamble and interrupted preamble rejected
    send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h00, 1'b0);
    send(8'hA7, 1'b0); send(8'd4, 1'b0);
    for (int i = 0; i < 6; i++) send(8'h77, 1'b0);
    chk(irq == 1'b0, "R2 three zeros rejected", int'(irq), 0);
    send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h55, 1'b0);
    send(8'h00, 1'b0); send(8'h00, 1'b0);
    send(8'hA7, 1'b0); send(8'd4, 1'b0);
    for (int i = 0; i < 6; i++) send(8'h77, 1'b0);
    chk(irq == 1'b0, "R2 broken preamble rejected", int'(irq), 0);

    // recovery frame, then R7 lockout while pending
    build(6, 8'h90, 1'b0);
    header(4, 8'd6);
    send_body(6, 1'b0, 1'b1);
    rd(0, w0);
    build(9, 8'hC3, 1'b1);
    header(4, 8'd9);
    send_body(9, 1'b0, 1'b0);
    chk(irq == 1'b1, "R7 irq still pending", int'(irq), 1);
    chk(frame_len == 7'd6, "R7 len frozen", int'(frame_len), 6);
    chk(crc_ok == 1'b1, "R7 crc flag frozen", int'(crc_ok), 1);
    rd(0, d);
    chk(d == w0, "R7 store untouched", int'(d), int'(w0));

    // R8: byte in the clearing cycle is ignored
    irq_clear  = 1'b1;
    byte_valid = 1'b1;
    byte_in    = 8'h00;
    @(negedge clk);
    irq_clear  = 1'b0;
    byte_valid = 1'b0;
    chk(irq == 1'b0, "R8 cleared with byte", int'(irq), 0);
    send(8'h00, 1'b0); send(8'h00, 1'b0); send(8'h00, 1'b0);
    send(8'hA7, 1'b0); send(8'd3, 1'b0);
    for (int i = 0; i < 5; i++) send(8'h61, 1'b0);
    chk(irq == 1'b0, "R8 byte at clear not counted", int'(irq), 0);
    build(4, 8'hE1, 1'b0);
    header(4, 8'd4);
    send_body(4, 1'b1, 1'b1);
    chk(frame_len == 7'd4 && crc_ok, "R8 R10 search resumed", int'({frame_len, crc_ok}), 9);
    verify_store(4, "R10 gapped store");
    clear_irq();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule